// File: doc/BRIEF.md
# Set-Associative Translation Lookaside Buffer

This block keeps recently used page mappings so that a 32-bit virtual address can be turned into a 30-bit physical address without a page-table access. Pages are 4 KiB. The low 12 address bits pass through unchanged, and the upper bits select a set and a tag in a 4-way, 32-set array of 128 entries. Each entry holds a valid flag, a tag, a physical page number, a small access field, a reference flag and a dirty flag.

A requester presents a virtual address and a write flag. One cycle later the block reports either a hit, with the physical address and the access field, or a miss. A miss names the missing virtual page number and stays raised until an external walker installs a mapping for that page through the refill port. Refill places the mapping in an invalid way if there is one. Otherwise it takes the way chosen by a 3-bit tree pseudo-LRU state kept per set. When a displaced entry was referenced or written, its page numbers and flags are reported for one cycle so that they can be written back. A single input drops every mapping at once.

Top module: `tlb_assoc`

## Requirements
- R1: A lookup (`lk_valid` high while `lk_miss` is low) uses virtual address bits 16..12 as set index and bits 31..17 as tag. On a match with a valid entry, `lk_hit` is high in the next cycle. In that cycle `lk_paddr` equals the stored 18-bit page number concatenated with virtual bits 11..0, and `lk_acc` returns the stored access field.
- R2: A lookup that finds no match raises `lk_miss` in the next cycle, with `miss_vpn` set to virtual bits 31..12. Both hold until a refill with `fill_vpn` equal to `miss_vpn` is accepted; `lk_miss` is low from the following cycle. While `lk_miss` is high, `lk_valid` is ignored and gives no hit.
- R3: Every hit sets the reference flag of the hit entry. A hit with `lk_write` high also sets its dirty flag.
- R4: A refill of a page not held in its set writes the lowest-numbered invalid way. If all four ways are valid, it writes the way named by the tree state. Root bit 0 at 0 picks ways 0/1 and at 1 picks ways 2/3. Bit 1 picks way 1 over way 0 when set, and bit 2 picks way 3 over way 2 when set. A new entry starts with both flags clear.
- R5: Each hit and each accepted refill updates its set's tree bits so they point away from the way used. When a hit and a refill touch the same set in one cycle, the refill's update is the one kept.
- R6: When a refill displaces a valid entry whose reference or dirty flag is set, `evict_valid` is high for exactly the next cycle. In that cycle `evict_vpn`, `evict_ppn`, `evict_dirty` and `evict_ref` carry the old entry's contents. Displacing an entry with both flags clear gives no report.
- R7: A refill of a page already held in its set overwrites that way's page number and access field in place. It keeps the flags and reports no eviction.
- R8: `inv_all` clears every valid flag at that clock edge, so later lookups miss. A refill offered in the same cycle is dropped, and no eviction is reported.
- R9: During and right after reset, `lk_hit`, `lk_miss` and `evict_valid` are low and all entries are invalid.
- R10: `lk_hit` and `lk_miss` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_write | input | 1 | Lookup is for a store |
| lk_hit | output | 1 | Previous-cycle lookup hit |
| lk_paddr | output | 30 | Translated physical address |
| lk_acc | output | 2 | Access field of the hit entry |
| lk_miss | output | 1 | A miss is waiting for refill |
| miss_vpn | output | 20 | Page number of the waiting miss |
| fill_valid | input | 1 | Refill write strobe |
| fill_vpn | input | 20 | Virtual page number to install |
| fill_ppn | input | 18 | Physical page number to install |
| fill_acc | input | 2 | Access field to install |
| inv_all | input | 1 | Drop every mapping |
| evict_valid | output | 1 | Write-back report strobe |
| evict_vpn | output | 20 | Displaced virtual page number |
| evict_ppn | output | 18 | Displaced physical page number |
| evict_dirty | output | 1 | Displaced entry had been written |
| evict_ref | output | 1 | Displaced entry had been referenced |

## Verification
Directed sequences fill one set with four pages and then hit chosen ways with reads and writes. Further refills then show whether the tree picks the expected victim, and whether clean, referenced-only and dirty victims are reported correctly. Other directed cases cover a lookup issued while a miss is pending, an in-place refill of a resident page, and invalidate-all with a refill in the same cycle. These separate a stuck miss flag from an ignored request, and a lost mapping from a stale one. A long constrained-random run follows. It draws pages from a few sets and tags, so hits, conflicts, simultaneous hit and refill in one set, and write-backs all occur often, and every cycle is compared against a bench model of the buffer.

// File: rtl/tlb_assoc_pkg.sv
package tlb_assoc_pkg;

   // 4-way tree: bit0 root (1 = right pair), bit1 left pair (1 = way1),
   // bit2 right pair (1 = way3). Bits name the next victim.
   function automatic logic [1:0] plru4_pick(input logic [2:0] st);
      if (st[0]) return st[2] ? 2'd3 : 2'd2;
      else       return st[1] ? 2'd1 : 2'd0;
   endfunction

   function automatic logic [2:0] plru4_touch(input logic [2:0] st, input logic [1:0] way);
      logic [2:0] n;
      n = st;
      if (way[1] == 1'b0) begin
         n[0] = 1'b1;
         n[1] = (way[0] == 1'b0);
      end else begin
         n[0] = 1'b0;
         n[2] = (way[0] == 1'b0);
      end
      return n;
   endfunction

endpackage

// File: rtl/tlb_assoc_match.sv
module tlb_assoc_match #(
   parameter int WAYS  = 4,
   parameter int TAG_W = 15,
   parameter int WAY_W = 2
) (
   input  logic [WAYS-1:0]            vld,
   input  logic [WAYS-1:0][TAG_W-1:0] tags,
   input  logic [TAG_W-1:0]           key,
   output logic                       any,
   output logic [WAY_W-1:0]           way
);
   logic [WAYS-1:0] hv;

   for (genvar g = 0; g < WAYS; g++) begin : g_cmp
      assign hv[g] = vld[g] && (tags[g] == key);
   end

   assign any = |hv;

   always_comb begin
      way = '0;
      for (int i = 0; i < WAYS; i++) begin
         if (hv[i]) way = WAY_W'(i);
      end
   end
endmodule

// File: rtl/tlb_assoc_plru.sv
module tlb_assoc_plru #(
   parameter int WAYS  = 4,
   parameter int WAY_W = 2,
   parameter int PL_W  = 3
) (
   input  logic [PL_W-1:0]  state,
   input  logic [WAYS-1:0]  vld,
   input  logic [WAY_W-1:0] touch,
   output logic [WAY_W-1:0] victim,
   output logic [PL_W-1:0]  nxt
);
   logic [WAY_W-1:0] tree_way;

   if (WAYS == 4) begin : g_tree4
      assign tree_way = tlb_assoc_pkg::plru4_pick(state);
      assign nxt      = tlb_assoc_pkg::plru4_touch(state, touch);
   end else begin : g_tree2
      assign tree_way = state;
      assign nxt      = ~touch;
   end

   always_comb begin
      logic found;
      found  = 1'b0;
      victim = tree_way;
      for (int i = 0; i < WAYS; i++) begin
         if (!vld[i] && !found) begin
            victim = WAY_W'(i);
            found  = 1'b1;
         end
      end
   end
endmodule

// File: rtl/tlb_assoc.sv
module tlb_assoc #(
   parameter int VA_W  = 32,
   parameter int PA_W  = 30,
   parameter int OFF_W = 12,
   parameter int SETS  = 32,
   parameter int WAYS  = 4,
   parameter int ACC_W = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    lk_valid,
   input  logic [VA_W-1:0]         lk_vaddr,
   input  logic                    lk_write,
   output logic                    lk_hit,
   output logic [PA_W-1:0]         lk_paddr,
   output logic [ACC_W-1:0]        lk_acc,
   output logic                    lk_miss,
   output logic [VA_W-OFF_W-1:0]   miss_vpn,
   input  logic                    fill_valid,
   input  logic [VA_W-OFF_W-1:0]   fill_vpn,
   input  logic [PA_W-OFF_W-1:0]   fill_ppn,
   input  logic [ACC_W-1:0]        fill_acc,
   input  logic                    inv_all,
   output logic                    evict_valid,
   output logic [VA_W-OFF_W-1:0]   evict_vpn,
   output logic [PA_W-OFF_W-1:0]   evict_ppn,
   output logic                    evict_dirty,
   output logic                    evict_ref
);
   localparam int VPN_W = VA_W - OFF_W;
   localparam int PPN_W = PA_W - OFF_W;
   localparam int IDX_W = $clog2(SETS);
   localparam int TAG_W = VPN_W - IDX_W;
   localparam int WAY_W = $clog2(WAYS);
   localparam int PL_W  = WAYS - 1;

   if (WAYS != 2 && WAYS != 4) begin : g_bad_ways
      $error("tlb_assoc: WAYS must be 2 or 4");
   end
   if (SETS < 2 || (1 << IDX_W) != SETS) begin : g_bad_sets
      $error("tlb_assoc: SETS must be a power of two, at least 2");
   end
   if (TAG_W < 1 || PPN_W < 1) begin : g_bad_widths
      $error("tlb_assoc: address widths leave no tag or page number");
   end

   logic [WAYS-1:0]             v_q   [SETS];
   logic [WAYS-1:0]             d_q   [SETS];
   logic [WAYS-1:0]             r_q   [SETS];
   logic [WAYS-1:0][TAG_W-1:0]  tag_q [SETS];
   logic [WAYS-1:0][PPN_W-1:0]  ppn_q [SETS];
   logic [WAYS-1:0][ACC_W-1:0]  acc_q [SETS];
   logic [PL_W-1:0]             pl_q  [SETS];

   logic                  miss_q;
   logic [VPN_W-1:0]      mvpn_q;
   logic                  hit_q;
   logic [PA_W-1:0]       pa_q;
   logic [ACC_W-1:0]      acc_o_q;
   logic                  ev_q;
   logic [VPN_W-1:0]      ev_vpn_q;
   logic [PPN_W-1:0]      ev_ppn_q;
   logic                  ev_d_q, ev_r_q;

   // lookup side
   logic [IDX_W-1:0] lk_idx;
   logic [TAG_W-1:0] lk_tag;
   logic             lk_go, lk_any;
   logic [WAY_W-1:0] lk_way, lk_vict_unused;
   logic [PL_W-1:0]  lk_pl_nxt;

   assign lk_idx = lk_vaddr[OFF_W +: IDX_W];
   assign lk_tag = lk_vaddr[VA_W-1 -: TAG_W];
   assign lk_go  = lk_valid && !miss_q;

   tlb_assoc_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_lk_match (
      .vld (v_q[lk_idx]),
      .tags(tag_q[lk_idx]),
      .key (lk_tag),
      .any (lk_any),
      .way (lk_way)
   );

   tlb_assoc_plru #(.WAYS(WAYS), .WAY_W(WAY_W), .PL_W(PL_W)) u_lk_plru (
      .state (pl_q[lk_idx]),
      .vld   ({WAYS{1'b1}}),
      .touch (lk_way),
      .victim(lk_vict_unused),
      .nxt   (lk_pl_nxt)
   );

   // refill side
   logic [IDX_W-1:0] f_idx;
   logic [TAG_W-1:0] f_tag;
   logic             f_go, f_res;
   logic [WAY_W-1:0] f_res_way, f_vict, f_way;
   logic [PL_W-1:0]  f_pl_nxt;

   assign f_idx = fill_vpn[IDX_W-1:0];
   assign f_tag = fill_vpn[VPN_W-1 -: TAG_W];
   assign f_go  = fill_valid && !inv_all;
   assign f_way = f_res ? f_res_way : f_vict;

   tlb_assoc_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_f_match (
      .vld (v_q[f_idx]),
      .tags(tag_q[f_idx]),
      .key (f_tag),
      .any (f_res),
      .way (f_res_way)
   );

   tlb_assoc_plru #(.WAYS(WAYS), .WAY_W(WAY_W), .PL_W(PL_W)) u_f_plru (
      .state (pl_q[f_idx]),
      .vld   (v_q[f_idx]),
      .touch (f_way),
      .victim(f_vict),
      .nxt   (f_pl_nxt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            v_q[s]   <= '0;
            d_q[s]   <= '0;
            r_q[s]   <= '0;
            tag_q[s] <= '0;
            ppn_q[s] <= '0;
            acc_q[s] <= '0;
            pl_q[s]  <= '0;
         end
         miss_q   <= 1'b0;
         mvpn_q   <= '0;
         hit_q    <= 1'b0;
         pa_q     <= '0;
         acc_o_q  <= '0;
         ev_q     <= 1'b0;
         ev_vpn_q <= '0;
         ev_ppn_q <= '0;
         ev_d_q   <= 1'b0;
         ev_r_q   <= 1'b0;
      end else begin
         hit_q <= lk_go && lk_any;
         ev_q  <= 1'b0;

         if (lk_go && !lk_any) begin
            miss_q <= 1'b1;
            mvpn_q <= lk_vaddr[VA_W-1:OFF_W];
         end else if (miss_q && f_go && (fill_vpn == mvpn_q)) begin
            miss_q <= 1'b0;
         end

         if (lk_go && lk_any) begin
            pa_q    <= {ppn_q[lk_idx][lk_way], lk_vaddr[OFF_W-1:0]};
            acc_o_q <= acc_q[lk_idx][lk_way];
            r_q[lk_idx][lk_way] <= 1'b1;
            if (lk_write) d_q[lk_idx][lk_way] <= 1'b1;
            pl_q[lk_idx] <= lk_pl_nxt;
         end

         if (f_go) begin
            ppn_q[f_idx][f_way] <= fill_ppn;
            acc_q[f_idx][f_way] <= fill_acc;
            if (!f_res) begin
               v_q[f_idx][f_way]   <= 1'b1;
               tag_q[f_idx][f_way] <= f_tag;
               d_q[f_idx][f_way]   <= 1'b0;
               r_q[f_idx][f_way]   <= 1'b0;
               ev_q     <= v_q[f_idx][f_vict] && (d_q[f_idx][f_vict] || r_q[f_idx][f_vict]);
               ev_vpn_q <= {tag_q[f_idx][f_vict], f_idx};
               ev_ppn_q <= ppn_q[f_idx][f_vict];
               ev_d_q   <= d_q[f_idx][f_vict];
               ev_r_q   <= r_q[f_idx][f_vict];
            end
            pl_q[f_idx] <= f_pl_nxt;
         end

         if (inv_all) begin
            for (int s = 0; s < SETS; s++) v_q[s] <= '0;
         end
      end
   end

   assign lk_hit      = hit_q;
   assign lk_paddr    = pa_q;
   assign lk_acc      = acc_o_q;
   assign lk_miss     = miss_q;
   assign miss_vpn    = mvpn_q;
   assign evict_valid = ev_q;
   assign evict_vpn   = ev_vpn_q;
   assign evict_ppn   = ev_ppn_q;
   assign evict_dirty = ev_d_q;
   assign evict_ref   = ev_r_q;
endmodule

// File: rtl/tlb_assoc_chk.sv
module tlb_assoc_chk #(
   parameter int VA_W  = 32,
   parameter int OFF_W = 12
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  lk_valid,
   input logic [VA_W-1:0]       lk_vaddr,
   input logic                  lk_hit,
   input logic [OFF_W-1:0]      pa_off,
   input logic                  lk_miss,
   input logic [VA_W-OFF_W-1:0] miss_vpn,
   input logic                  fill_valid,
   input logic [VA_W-OFF_W-1:0] fill_vpn,
   input logic                  inv_all,
   input logic                  evict_valid,
   input logic                  evict_dirty,
   input logic                  evict_ref
);
   logic clr;
   assign clr = fill_valid && !inv_all && (fill_vpn == miss_vpn);

   a_r10_hit_miss_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(lk_hit && lk_miss));

   a_r2_miss_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_miss && !clr) |=> (lk_miss && $stable(miss_vpn)));

   a_r2_miss_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_miss && clr) |=> !lk_miss);

   a_r2_ignored_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_miss && lk_valid) |=> !lk_hit);

   a_r1_answer_next: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && !lk_miss) |=> (lk_hit || lk_miss));

   a_r1_offset_through: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> (pa_off == $past(lk_vaddr[OFF_W-1:0])));

   a_r6_evict_flags: assert property (@(posedge clk) disable iff (!rst_n)
      evict_valid |-> (evict_dirty || evict_ref));

   a_r6_evict_after_fill: assert property (@(posedge clk) disable iff (!rst_n)
      evict_valid |-> $past(fill_valid && !inv_all));

   a_r8_inv_no_evict: assert property (@(posedge clk) disable iff (!rst_n)
      inv_all |=> !evict_valid);
endmodule

bind tlb_assoc tlb_assoc_chk #(.VA_W(VA_W), .OFF_W(OFF_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .lk_valid   (lk_valid),
   .lk_vaddr   (lk_vaddr),
   .lk_hit     (lk_hit),
   .pa_off     (lk_paddr[OFF_W-1:0]),
   .lk_miss    (lk_miss),
   .miss_vpn   (miss_vpn),
   .fill_valid (fill_valid),
   .fill_vpn   (fill_vpn),
   .inv_all    (inv_all),
   .evict_valid(evict_valid),
   .evict_dirty(evict_dirty),
   .evict_ref  (evict_ref)
);

// File: tb/tb_tlb_assoc.sv
module tb_tlb_assoc;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_valid = 0, lk_write = 0, fill_valid = 0, inv_all = 0;
   logic [31:0] lk_vaddr = '0;
   logic [19:0] fill_vpn = '0;
   logic [17:0] fill_ppn = '0;
   logic [1:0]  fill_acc = '0;
   logic        lk_hit, lk_miss, evict_valid, evict_dirty, evict_ref;
   logic [29:0] lk_paddr;
   logic [1:0]  lk_acc;
   logic [19:0] miss_vpn, evict_vpn;
   logic [17:0] evict_ppn;

   always #10 clk = ~clk;

   tlb_assoc dut (.*);

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   // bench model
   logic        mv   [32][4];
   logic [14:0] mtag [32][4];
   logic [17:0] mppn [32][4];
   logic [1:0]  macc [32][4];
   logic        md   [32][4];
   logic        mr   [32][4];
   logic [2:0]  mpl  [32];
   logic        mmiss;
   logic [19:0] mmvpn;
   logic        e_hit, e_ev, e_evd, e_evr;
   logic [29:0] e_pa;
   logic [1:0]  e_acc;
   logic [19:0] e_evvpn;
   logic [17:0] e_evppn;

   function automatic int pick(input logic [2:0] s);
      if (s[0]) return s[2] ? 3 : 2;
      return s[1] ? 1 : 0;
   endfunction

   function automatic logic [2:0] touch(input logic [2:0] s, input int w);
      logic [2:0] n = s;
      if (w < 2) begin n[0] = 1; n[1] = (w == 0); end
      else       begin n[0] = 0; n[2] = (w == 2); end
      return n;
   endfunction

   task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int s = 0; s < 32; s++) begin
         for (int w = 0; w < 4; w++) begin
            mv[s][w] = 0; mtag[s][w] = 0; mppn[s][w] = 0; macc[s][w] = 0; md[s][w] = 0; mr[s][w] = 0;
         end
         mpl[s] = 0;
      end
      mmiss = 0; mmvpn = 0;
   endtask

   task automatic model_step(input logic lv, input logic [31:0] va, input logic wr,
                             input logic fv, input logic [19:0] fvpn, input logic [17:0] fppn,
                             input logic [1:0] facc, input logic inv);
      int hw = -1, fres = -1, fw = -1;
      int idx = int'(va[16:12]);
      int fi  = int'(fvpn[4:0]);
      logic lgo = lv && !mmiss;
      logic fgo = fv && !inv;
      logic nmiss = mmiss;
      logic [2:0] old_fpl = mpl[fi];
      e_hit = 0; e_ev = 0;
      if (lgo) for (int w = 0; w < 4; w++) if (mv[idx][w] && mtag[idx][w] == va[31:17]) hw = w;
      if (fgo) begin
         for (int w = 0; w < 4; w++) if (mv[fi][w] && mtag[fi][w] == fvpn[19:5]) fres = w;
         if (fres >= 0) fw = fres;
         else begin
            for (int w = 3; w >= 0; w--) if (!mv[fi][w]) fw = w;
            if (fw < 0) fw = pick(old_fpl);
            if (mv[fi][fw] && (md[fi][fw] || mr[fi][fw])) begin
               e_ev = 1; e_evvpn = {mtag[fi][fw], fvpn[4:0]}; e_evppn = mppn[fi][fw];
               e_evd = md[fi][fw]; e_evr = mr[fi][fw];
            end
         end
      end
      if (lgo && hw < 0) begin nmiss = 1; mmvpn = va[31:12]; end
      else if (mmiss && fgo && fvpn == mmvpn) nmiss = 0;
      if (lgo && hw >= 0) begin
         e_hit = 1; e_pa = {mppn[idx][hw], va[11:0]}; e_acc = macc[idx][hw];
         mr[idx][hw] = 1;
         if (wr) md[idx][hw] = 1;
         mpl[idx] = touch(mpl[idx], hw);
      end
      if (fgo) begin
         mppn[fi][fw] = fppn; macc[fi][fw] = facc;
         if (fres < 0) begin
            mv[fi][fw] = 1; mtag[fi][fw] = fvpn[19:5]; md[fi][fw] = 0; mr[fi][fw] = 0;
         end
         mpl[fi] = touch(old_fpl, fw);
      end
      if (inv) for (int s = 0; s < 32; s++) for (int w = 0; w < 4; w++) mv[s][w] = 0;
      mmiss = nmiss;
   endtask

   task automatic step(input logic lv, input logic [31:0] va, input logic wr,
                       input logic fv, input logic [19:0] fvpn, input logic [17:0] fppn,
                       input logic [1:0] facc, input logic inv);
      @(negedge clk);
      lk_valid = lv; lk_vaddr = va; lk_write = wr;
      fill_valid = fv; fill_vpn = fvpn; fill_ppn = fppn; fill_acc = facc; inv_all = inv;
      model_step(lv, va, wr, fv, fvpn, fppn, facc, inv);
      @(posedge clk); #5;
      chk(lk_hit == e_hit, "R1 hit flag", 64'(lk_hit), 64'(e_hit));
      if (e_hit) begin
         chk(lk_paddr == e_pa, "R1 paddr", 64'(lk_paddr), 64'(e_pa));
         chk(lk_acc == e_acc, "R1 access field", 64'(lk_acc), 64'(e_acc));
      end
      chk(lk_miss == mmiss, "R2 miss flag", 64'(lk_miss), 64'(mmiss));
      if (mmiss) chk(miss_vpn == mmvpn, "R2 miss vpn", 64'(miss_vpn), 64'(mmvpn));
      chk(evict_valid == e_ev, "R6 evict strobe", 64'(evict_valid), 64'(e_ev));
      if (e_ev) begin
         chk(evict_vpn == e_evvpn, "R6 evict vpn", 64'(evict_vpn), 64'(e_evvpn));
         chk(evict_ppn == e_evppn, "R6 evict ppn", 64'(evict_ppn), 64'(e_evppn));
         chk({evict_dirty, evict_ref} == {e_evd, e_evr}, "R6 evict flags",
             64'({evict_dirty, evict_ref}), 64'({e_evd, e_evr}));
      end
   endtask

   task automatic look(input logic [19:0] vpn, input logic [11:0] off, input logic wr);
      step(1, {vpn, off}, wr, 0, '0, '0, '0, 0);
   endtask

   task automatic fill(input logic [19:0] vpn, input logic [17:0] ppn, input logic [1:0] acc);
      step(0, '0, 0, 1, vpn, ppn, acc, 0);
   endtask

   function automatic logic [19:0] s3(input int t);
      return {15'(t), 5'd3};
   endfunction

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++; n_chk++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

   initial begin
      int unsigned seed = $urandom(32'h1bad5eed);
      model_reset();
      repeat (3) @(posedge clk);
      #5;
      // R9: outputs quiet in reset
      chk(!lk_hit && !lk_miss && !evict_valid, "R9 reset outputs", 64'({lk_hit, lk_miss, evict_valid}), 64'd0);
      @(negedge clk); rst_n = 1;
      look(20'h00012, 12'h345, 0);
      chk(lk_miss && miss_vpn == 20'h00012, "R9 empty after reset misses", 64'(miss_vpn), 64'h12);

      // R2: pending miss ignores lookups, clears on matching refill
      look(20'h00012, 12'h345, 0);
      chk(!lk_hit && lk_miss, "R2 lookup ignored while pending", 64'({lk_hit, lk_miss}), 64'b01);
      fill(20'h00099, 18'h11111, 2'd0);
      chk(lk_miss, "R2 unrelated refill keeps miss", 64'(lk_miss), 64'd1);
      fill(20'h00012, 18'h2ABCD, 2'd2);
      chk(!lk_miss, "R2 matching refill clears miss", 64'(lk_miss), 64'd0);
      look(20'h00012, 12'h345, 0);
      chk(lk_hit && lk_paddr == {18'h2ABCD, 12'h345} && lk_acc == 2'd2, "R1 translated address",
          64'(lk_paddr), 64'({18'h2ABCD, 12'h345}));

      // R4/R5/R3/R6: set 3 victim sequence
      for (int t = 1; t <= 4; t++) fill(s3(t), 18'(16'hA000 + t), 2'd1);
      look(s3(1), 12'h010, 1);                 // way0 dirty+ref
      fill(s3(5), 18'hA005, 2'd1);             // evicts tag3 (clean)
      chk(!evict_valid, "R6 clean victim not reported", 64'(evict_valid), 64'd0);
      look(s3(2), 12'h020, 0);                 // way1 ref
      fill(s3(6), 18'hA006, 2'd1);             // evicts tag4 (clean)
      chk(!evict_valid, "R4 tree victim tag4 clean", 64'(evict_valid), 64'd0);
      fill(s3(7), 18'hA007, 2'd1);             // evicts tag1 dirty
      chk(evict_valid && evict_vpn == s3(1) && evict_dirty && evict_ref && evict_ppn == 18'hA001,
          "R3 R5 dirty victim reported", 64'(evict_vpn), 64'(s3(1)));
      look(s3(5), 12'h0, 0);                   // way2 ref, tree now names way1
      fill(s3(8), 18'hA008, 2'd1);
      chk(evict_valid && evict_vpn == s3(2) && !evict_dirty && evict_ref,
          "R4 R3 referenced-only victim", 64'({evict_vpn, evict_dirty, evict_ref}), 64'({s3(2), 2'b01}));

      // R7: in-place refill
      fill(s3(6), 18'h3FFFF, 2'd3);
      chk(!evict_valid, "R7 resident refill no eviction", 64'(evict_valid), 64'd0);
      look(s3(6), 12'hFFF, 0);
      chk(lk_hit && lk_paddr == {18'h3FFFF, 12'hFFF} && lk_acc == 2'd3, "R7 updated in place",
          64'(lk_paddr), 64'({18'h3FFFF, 12'hFFF}));

      // R8: invalidate-all with simultaneous refill
      step(0, '0, 0, 1, 20'h00444, 18'h00444, 2'd0, 1);
      chk(!evict_valid, "R8 no eviction on invalidate", 64'(evict_valid), 64'd0);
      look(s3(6), 12'h0, 0);
      chk(!lk_hit && lk_miss, "R8 mapping gone after invalidate", 64'({lk_hit, lk_miss}), 64'b01);
      fill(s3(6), 18'h00006, 2'd0);
      look(20'h00444, 12'h0, 0);
      chk(lk_miss && miss_vpn == 20'h00444, "R8 same-cycle refill dropped", 64'(miss_vpn), 64'h444);
      fill(20'h00444, 18'h00444, 2'd0);

      // constrained random
      for (int i = 0; i < 4000; i++) begin
         int unsigned r = $urandom % 100;
         logic [19:0] vpn = {15'($urandom % 6), 5'($urandom % 3)};
         logic        lv = (r < 60);
         logic        fv = ($urandom % 100) < 30;
         logic        inv = (($urandom % 200) == 0);
         logic [19:0] fvpn = (mmiss && ($urandom % 10) < 7) ? mmvpn
                                                            : {15'($urandom % 6), 5'($urandom % 3)};
         step(lv, {vpn, 12'($urandom)}, 1'($urandom), fv, fvpn, 18'($urandom), 2'($urandom), inv);
      end
      if (seed == 0) $display("seed zero");

      done = 1;
      summary();
      $finish;
   end
endmodule